// File: doc/BRIEF.md
# Peak detector with output decimation

This block sits behind a FIR filter that produces two filtered samples per bunch-crossing period, and it reduces that stream to one scaled value per crossing. Each filtered sample is cut to its upper 16 bits. A three-sample window then tests whether the middle sample is a local maximum. Of each pair of consecutive candidates, one is kept according to a phase setting. The kept value is divided by 1, 2, 4 or 8 with a right shift. Its low ten bits form the result, and any set bit above them raises an overflow flag.

The datapath runs on a clock at eight times the crossing rate, and input samples are qualified by a strobe. The result is registered, so the ready strobe rises one clock after the input strobe that completes the window, whichever phase is selected. With the peak test switched off, the kept middle sample goes through unchanged and is only scaled.

Top module: `peak_decim`

## Requirements
- R1: Only `in_data[18:3]` enters the datapath. Changing bits 2..0 of any sample never changes an output.
- R2: Samples are numbered from 0, starting at the first strobe after reset. Only the candidate centred on a sample whose index parity equals `phase_sel` produces an output. Two ready strobes never come on consecutive clocks.
- R3: With `peak_en`=1, the candidate is the middle sample if it is strictly greater than the older neighbour and greater than or equal to the newer neighbour. Otherwise the candidate is 0.
- R4: With `peak_en`=0, the candidate is always the middle sample.
- R5: The candidate is shifted right by `div_code` bits (0 to 3), and `out_value` is bits 9..0 of the shifted value.
- R6: `out_ovf` is the OR of bits 15..10 of the shifted candidate.
- R7: A synchronous reset (`rst`=1) clears the window and the parity. `out_valid`, `out_value` and `out_ovf` read 0 afterwards. No ready strobe appears until three samples have been received.
- R8: `out_valid` pulses for one clock, exactly one clock after the input strobe that brings in the newer neighbour of a kept candidate. This latency is the same for both phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Datapath clock, eight times the crossing rate |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe qualifying `in_data` |
| in_data | input | 19 | Filtered sample from the convolver |
| phase_sel | input | 1 | Parity of the sample indices that are kept |
| peak_en | input | 1 | 1 enables the three-point peak test |
| div_code | input | 2 | Right-shift amount, 0 to 3 |
| out_valid | output | 1 | One-clock ready strobe |
| out_value | output | 10 | Scaled result |
| out_ovf | output | 1 | Set when significant bits were lost in scaling |

## Verification
The situations that are hardest to reach from the ports are a flat-topped pulse whose equal samples straddle the decimation parity, and a peak large enough to overflow only at small divisors. The stimulus covers them with directed pulse shapes: a ramp, a single peak, a two-sample plateau, a falling edge and a near-full-scale spike. These are mixed with random samples whose low three bits are random as well. Every combination of phase, enable and divisor is run from a fresh reset, so the first three samples and the parity start point are covered for each setting.

// File: rtl/peak_decim_pkg.sv
package peak_decim_pkg;
    localparam int unsigned PD_IN_W  = 19;
    localparam int unsigned PD_CMP_W = 16;
    localparam int unsigned PD_OUT_W = 10;
    localparam int unsigned PD_SH_W  = 2;

    typedef enum logic [1:0] {
        DIV_BY_1 = 2'd0,
        DIV_BY_2 = 2'd1,
        DIV_BY_4 = 2'd2,
        DIV_BY_8 = 2'd3
    } div_code_e;
endpackage

// File: rtl/peak_decim_window.sv
module peak_decim_window #(
    parameter int unsigned CMP_W = peak_decim_pkg::PD_CMP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [CMP_W-1:0] din,
    input  logic             phase_sel,
    output logic [CMP_W-1:0] s_old,
    output logic [CMP_W-1:0] s_mid,
    output logic             full,
    output logic             keep_mid
);
    typedef struct packed {
        logic [CMP_W-1:0] newest;
        logic [CMP_W-1:0] older;
        logic [1:0]       fill;
        logic             par;
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (push) begin
            win_d.older  = win_q.newest;
            win_d.newest = din;
            win_d.par    = ~win_q.par;
            if (win_q.fill != 2'd2) begin
                win_d.fill = win_q.fill + 2'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    // The stored newest sample becomes the middle sample once din arrives.
    assign s_old    = win_q.older;
    assign s_mid    = win_q.newest;
    assign full     = (win_q.fill == 2'd2);
    // par_q is the parity of the incoming sample's index; the middle sample is one earlier.
    assign keep_mid = full && ((~win_q.par) == phase_sel);

    assert_fill_bound_R7: assert property (@(posedge clk) disable iff (rst)
        win_q.fill != 2'd3);

    assert_par_toggle_R2: assert property (@(posedge clk) disable iff (rst)
        push |=> (win_q.par != $past(win_q.par)));
endmodule

// File: rtl/peak_decim_cmp.sv
module peak_decim_cmp #(
    parameter int unsigned CMP_W = peak_decim_pkg::PD_CMP_W
) (
    input  logic [CMP_W-1:0] s_old,
    input  logic [CMP_W-1:0] s_mid,
    input  logic [CMP_W-1:0] s_new,
    input  logic             peak_en,
    output logic [CMP_W-1:0] cand
);
    logic is_peak;

    // Strict test on the rising side, inclusive on the falling side: a plateau reports once.
    always_comb begin
        is_peak = (s_mid > s_old) && (s_mid >= s_new);
        if (!peak_en) begin
            cand = s_mid;
        end else if (is_peak) begin
            cand = s_mid;
        end else begin
            cand = '0;
        end
    end
endmodule

// File: rtl/peak_decim_scale.sv
module peak_decim_scale #(
    parameter int unsigned CMP_W = peak_decim_pkg::PD_CMP_W,
    parameter int unsigned OUT_W = peak_decim_pkg::PD_OUT_W,
    parameter int unsigned SH_W  = peak_decim_pkg::PD_SH_W
) (
    input  logic [CMP_W-1:0] din,
    input  logic [SH_W-1:0]  shamt,
    output logic [OUT_W-1:0] dout,
    output logic             ovf
);
    logic [CMP_W-1:0] shifted;

    always_comb begin
        shifted = din >> shamt;
        dout    = shifted[OUT_W-1:0];
    end

    generate
        if (CMP_W > OUT_W) begin : g_ovf
            assign ovf = |shifted[CMP_W-1:OUT_W];
        end else begin : g_no_ovf
            assign ovf = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/peak_decim.sv
module peak_decim #(
    parameter int unsigned IN_W  = peak_decim_pkg::PD_IN_W,
    parameter int unsigned CMP_W = peak_decim_pkg::PD_CMP_W,
    parameter int unsigned OUT_W = peak_decim_pkg::PD_OUT_W,
    parameter int unsigned SH_W  = peak_decim_pkg::PD_SH_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    input  logic             phase_sel,
    input  logic             peak_en,
    input  logic [SH_W-1:0]  div_code,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_value,
    output logic             out_ovf
);
    localparam int unsigned DROP_W = IN_W - CMP_W;

    typedef struct packed {
        logic             valid;
        logic [OUT_W-1:0] value;
        logic             ovf;
    } res_t;

    logic [CMP_W-1:0] s_new, s_old, s_mid, cand, dummy_unused;
    logic [OUT_W-1:0] scaled;
    logic             full, keep_mid, scaled_ovf;
    res_t             res_d, res_q;

    assign s_new = in_data[IN_W-1:DROP_W];
    assign dummy_unused = '0;

    peak_decim_window #(.CMP_W(CMP_W)) u_win (
        .clk(clk), .rst(rst), .push(in_valid), .din(s_new), .phase_sel(phase_sel),
        .s_old(s_old), .s_mid(s_mid), .full(full), .keep_mid(keep_mid)
    );

    peak_decim_cmp #(.CMP_W(CMP_W)) u_cmp (
        .s_old(s_old), .s_mid(s_mid), .s_new(s_new), .peak_en(peak_en), .cand(cand)
    );

    peak_decim_scale #(.CMP_W(CMP_W), .OUT_W(OUT_W), .SH_W(SH_W)) u_scale (
        .din(cand), .shamt(div_code), .dout(scaled), .ovf(scaled_ovf)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = in_valid && keep_mid;
        if (res_d.valid) begin
            res_d.value = scaled;
            res_d.ovf   = scaled_ovf;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.valid;
    assign out_value = res_q.value;
    assign out_ovf   = res_q.ovf;

    assert_ready_follows_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(in_valid));

    assert_no_early_ready_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !full) |=> !out_valid);

    assert_single_ready_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    assert_zero_non_peak_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && keep_mid && peak_en && !(s_mid > s_old)) |=> (out_value == '0 && !out_ovf));
endmodule

// File: tb/peak_decim_tb.sv
module peak_decim_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [18:0] in_data = '0;
    logic        phase_sel = 1'b0;
    logic        peak_en = 1'b0;
    logic [1:0]  div_code = 2'd0;
    logic        out_valid;
    logic [9:0]  out_value;
    logic        out_ovf;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int hist [0:63];
    int n_s;

    always #4 clk = ~clk;

    peak_decim u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .phase_sel(phase_sel), .peak_en(peak_en), .div_code(div_code),
        .out_valid(out_valid), .out_value(out_value), .out_ovf(out_ovf)
    );

    function automatic int ref_cand(int a, int b, int c, bit en);
        if (!en) return b;
        if (b > a && b >= c) return b;
        return 0;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        n_s = 0;
        check(out_valid == 1'b0, "R7 valid after reset", int'(out_valid), 0);
        check(out_value == 10'd0 && out_ovf == 1'b0, "R7 value after reset",
              int'(out_value), 0);
    endtask

    task automatic push(logic [18:0] d);
        int t, k, sh;
        bit exp_v;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        @(negedge clk);
        in_valid = 1'b0;
        t = int'(d[18:3]);
        hist[n_s] = t;
        exp_v = (n_s >= 2) && (((n_s - 1) % 2) == int'(phase_sel));
        check(out_valid == exp_v, "R2 R7 R8 ready strobe", int'(out_valid), int'(exp_v));
        if (exp_v) begin
            k  = ref_cand(hist[n_s-2], hist[n_s-1], hist[n_s], peak_en);
            sh = k >> div_code;
            if (peak_en)
                check(out_value == 10'(sh), "R1 R3 R5 value", int'(out_value), sh & 1023);
            else
                check(out_value == 10'(sh), "R1 R4 R5 value", int'(out_value), sh & 1023);
            check(out_ovf == ((sh >> 10) != 0), "R6 overflow", int'(out_ovf),
                  int'((sh >> 10) != 0));
        end
        n_s++;
        @(negedge clk);
        check(out_valid == 1'b0, "R8 one-clock strobe", int'(out_valid), 0);
        @(negedge clk);
    endtask

    function automatic logic [18:0] mk(int upper);
        return {16'(upper), 3'($urandom_range(0, 7))};
    endfunction

    initial begin
        int seed_v;
        seed_v = $urandom(32'd1234);
        for (int ph = 0; ph < 2; ph++) begin
            for (int en = 0; en < 2; en++) begin
                for (int dv = 0; dv < 4; dv++) begin
                    phase_sel = ph[0];
                    peak_en   = en[0];
                    div_code  = dv[1:0];
                    do_reset();
                    // ramp, single peak, fall
                    push(mk(100)); push(mk(300)); push(mk(900)); push(mk(500));
                    push(mk(200));
                    // plateau (flat top) on both parities
                    push(mk(400)); push(mk(800)); push(mk(800)); push(mk(300));
                    push(mk(100)); push(mk(700)); push(mk(700)); push(mk(700));
                    push(mk(50));
                    // near full scale spike for overflow
                    push(mk(10)); push(mk(65535)); push(mk(20)); push(mk(60000));
                    push(mk(1023)); push(mk(8191));
                    // random tail
                    for (int i = 0; i < 10; i++) push(mk(int'($urandom_range(0, 65535))));
                    // R1: same upper bits with different low bits give the same kept result
                    push({16'd3000, 3'd7}); push({16'd3000, 3'd0});
                end
            end
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule